// File: doc/BRIEF.md
# Windowed Error-Rate Monitor

This block supervises a circulating-token reliability test. A run is a fixed number of observation windows. Each window begins with a clear phase that returns the ring to its idle pattern, followed by a one-cycle token injection. After that the block watches two event inputs, one for a lost token and one for an extra token. A window closes on the first event, or when its cycle limit is reached with no event. The next window then starts with a fresh clear and injection.

Across the run the block sums the cycles that were actually observed, with each window capped at its limit. It also counts the windows that closed on an error and the windows completed. Software takes the summed observation time and the error count and divides one by the other to get the mean time between failures. The statistics are cleared when a run starts and are held after it ends, until the next start.

Top module: `err_window_monitor`

## Requirements
- R1: After reset, `inject_o`, `clear_o` and `done_o` are low, all three statistics outputs are zero, and the block is idle.
- R2: A `start_i` sampled high while idle zeroes the statistics. `clear_o` is then high for exactly CLEAR_LEN (default 10) consecutive cycles, beginning the cycle after that start. The same clear phase opens every later window.
- R3: `inject_o` is high for exactly one cycle, directly after each clear phase. Observation begins in the following cycle.
- R4: A window ends at the first observation cycle in which `lost_i` or `extra_i` is high, or at its WIN_LEN-th observation cycle (default 16) if neither is seen. The next clear phase starts in the cycle after the window ends.
- R5: `obs_cycles_o` rises by one at the end of every observation cycle, so after a run it equals the sum of the window durations, each capped at WIN_LEN.
- R6: `err_count_o` rises by one for each window that ends on an error. An error in the WIN_LEN-th observation cycle counts as an error.
- R7: `windows_o` rises by one for each window that ends. After NUM_WIN windows (default 180) no further window is opened.
- R8: `done_o` is high for the single cycle after the last window ends. The block then returns to idle, and the statistics hold their values until the next accepted start.
- R9: `start_i` has no effect while a run is in progress.
- R10: `lost_i` and `extra_i` have no effect outside observation cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken only while idle) |
| lost_i | input | 1 | Token-loss event |
| extra_i | input | 1 | Extra-token event |
| inject_o | output | 1 | One-cycle token injection strobe |
| clear_o | output | 1 | Ring clear request |
| obs_cycles_o | output | OBS_W | Summed observed cycles |
| err_count_o | output | CNT_W | Windows that ended on an error |
| windows_o | output | CNT_W | Windows completed |
| done_o | output | 1 | Run finished (one-cycle pulse) |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and free of unknown values. They place no limit on how often or when the event inputs or `start_i` are asserted. The stimulus changes every input only on the falling edge. It mixes runs with no events at all, runs with pseudo-random events and start pulses in every phase, and a directed run that places one event at each observation offset from the first cycle up to the limit. That directed run also places events a few cycles past the limit, where they fall into the clear phase.

// File: rtl/emon_pkg.sv
package emon_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_INJECT,
    ST_OBSERVE,
    ST_DONE
  } emon_state_e;
endpackage

// File: rtl/emon_timer.sv
module emon_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (restart_i)     cnt_o <= '0;
    else if (cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/emon_ctrl.sv
module emon_ctrl
  import emon_pkg::*;
#(
  parameter int unsigned CLEAR_LEN = 10,
  parameter int unsigned WIN_LEN   = 16,
  parameter int unsigned TW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          event_i,
  input  logic          last_win_i,
  input  logic [TW-1:0] tcnt_i,
  output logic          restart_o,
  output logic          run_start_o,
  output logic          observe_o,
  output logic          win_end_o,
  output logic          win_err_o,
  output logic          clear_o,
  output logic          inject_o,
  output logic          done_o
);
  emon_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    win_end_o   = 1'b0;
    win_err_o   = 1'b0;
    run_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d     = ST_CLEAR;
        run_start_o = 1'b1;
      end
      ST_CLEAR:  if (tcnt_i == TW'(CLEAR_LEN - 1)) state_d = ST_INJECT;
      ST_INJECT: state_d = ST_OBSERVE;
      ST_OBSERVE: if (event_i || tcnt_i == TW'(WIN_LEN - 1)) begin
        win_end_o = 1'b1;
        win_err_o = event_i;  // tie with limit counts as error
        state_d   = last_win_i ? ST_DONE : ST_CLEAR;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign restart_o = (state_d != state_q);
  assign observe_o = (state_q == ST_OBSERVE);
  assign clear_o   = (state_q == ST_CLEAR);
  assign inject_o  = (state_q == ST_INJECT);
  assign done_o    = (state_q == ST_DONE);

  p_inject_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> !inject_o);
  p_inject_after_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inject_o) |-> $past(clear_o));
  p_observe_after_inject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> observe_o);
  p_window_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    observe_o |-> tcnt_i < TW'(WIN_LEN));
endmodule

// File: rtl/emon_stats.sv
module emon_stats #(
  parameter int unsigned NUM_WIN = 180,
  parameter int unsigned WIN_LEN = 16,
  parameter int unsigned OBS_W   = 12,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_start_i,
  input  logic             observe_i,
  input  logic             win_end_i,
  input  logic             win_err_i,
  output logic             last_win_o,
  output logic [OBS_W-1:0] obs_o,
  output logic [CNT_W-1:0] err_o,
  output logic [CNT_W-1:0] win_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obs_o <= '0;
      err_o <= '0;
      win_o <= '0;
    end else if (run_start_i) begin
      obs_o <= '0;
      err_o <= '0;
      win_o <= '0;
    end else begin
      if (observe_i)              obs_o <= obs_o + 1'b1;
      if (win_end_i)              win_o <= win_o + 1'b1;
      if (win_end_i && win_err_i) err_o <= err_o + 1'b1;
    end
  end

  assign last_win_o = (win_o == CNT_W'(NUM_WIN - 1));

  p_err_le_win_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o <= win_o);
  p_win_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(win_o) <= int'(NUM_WIN));
  p_obs_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(obs_o) <= int'(win_o) * int'(WIN_LEN) + int'(WIN_LEN));
  p_obs_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!observe_i && !run_start_i) |=> $stable(obs_o));
endmodule

// File: rtl/err_window_monitor.sv
module err_window_monitor #(
  parameter int unsigned NUM_WIN   = 180,
  parameter int unsigned WIN_LEN   = 16,
  parameter int unsigned CLEAR_LEN = 10,
  localparam int unsigned OBS_W    = $clog2(NUM_WIN * WIN_LEN + 1),
  localparam int unsigned CNT_W    = $clog2(NUM_WIN + 1),
  localparam int unsigned TMAX     = (WIN_LEN > CLEAR_LEN) ? WIN_LEN : CLEAR_LEN,
  localparam int unsigned TW       = $clog2(TMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             lost_i,
  input  logic             extra_i,
  output logic             inject_o,
  output logic             clear_o,
  output logic [OBS_W-1:0] obs_cycles_o,
  output logic [CNT_W-1:0] err_count_o,
  output logic [CNT_W-1:0] windows_o,
  output logic             done_o
);
  logic          restart, run_start, observe, win_end, win_err, last_win;
  logic [TW-1:0] tcnt;

  emon_timer #(.W(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .cnt_o     (tcnt)
  );

  emon_ctrl #(.CLEAR_LEN(CLEAR_LEN), .WIN_LEN(WIN_LEN), .TW(TW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .event_i     (lost_i | extra_i),
    .last_win_i  (last_win),
    .tcnt_i      (tcnt),
    .restart_o   (restart),
    .run_start_o (run_start),
    .observe_o   (observe),
    .win_end_o   (win_end),
    .win_err_o   (win_err),
    .clear_o     (clear_o),
    .inject_o    (inject_o),
    .done_o      (done_o)
  );

  emon_stats #(.NUM_WIN(NUM_WIN), .WIN_LEN(WIN_LEN), .OBS_W(OBS_W), .CNT_W(CNT_W)) u_stats (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_start_i (run_start),
    .observe_i   (observe),
    .win_end_i   (win_end),
    .win_err_i   (win_err),
    .last_win_o  (last_win),
    .obs_o       (obs_cycles_o),
    .err_o       (err_count_o),
    .win_o       (windows_o)
  );

  p_done_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> int'(windows_o) == int'(NUM_WIN));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_outs_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clear_o, inject_o, done_o}));
endmodule

// File: tb/err_window_monitor_tb.sv
`timescale 1ns/1ps
module err_window_monitor_tb;
  localparam int NUM_WIN   = 180;
  localparam int WIN_LEN   = 16;
  localparam int CLEAR_LEN = 10;
  localparam int OBS_W     = $clog2(NUM_WIN * WIN_LEN + 1);
  localparam int CNT_W     = $clog2(NUM_WIN + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, lost_i = 1'b0, extra_i = 1'b0;
  logic inject_o, clear_o, done_o;
  logic [OBS_W-1:0] obs_cycles_o;
  logic [CNT_W-1:0] err_count_o, windows_o;

  err_window_monitor #(.NUM_WIN(NUM_WIN), .WIN_LEN(WIN_LEN), .CLEAR_LEN(CLEAR_LEN)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .lost_i(lost_i), .extra_i(extra_i),
    .inject_o(inject_o), .clear_o(clear_o), .obs_cycles_o(obs_cycles_o),
    .err_count_o(err_count_o), .windows_o(windows_o), .done_o(done_o)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 clear, 2 inject, 3 observe, 4 done
  int m_mode = 0, m_cnt = 0, m_obs = 0, m_err = 0, m_win = 0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_cnt = 0; m_obs = 0; m_err = 0; m_win = 0;
    end else begin
      case (m_mode)
        0: if (start_i) begin m_obs = 0; m_err = 0; m_win = 0; m_mode = 1; m_cnt = 0; end
        1: begin m_cnt++; if (m_cnt == CLEAR_LEN) m_mode = 2; end
        2: begin m_mode = 3; m_cnt = 0; end
        3: begin
          m_obs++; m_cnt++;
          if (lost_i || extra_i || m_cnt == WIN_LEN) begin
            m_win++;
            if (lost_i || extra_i) m_err++;
            m_mode = (m_win == NUM_WIN) ? 4 : 1;
            m_cnt = 0;
          end
        end
        default: m_mode = 0;
      endcase
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    chk("R2 clear_o",      int'(clear_o),      int'(m_mode == 1));
    chk("R3 inject_o",     int'(inject_o),     int'(m_mode == 2));
    chk("R5 obs_cycles_o", int'(obs_cycles_o), m_obs);
    chk("R6 err_count_o",  int'(err_count_o),  m_err);
    chk("R7 windows_o",    int'(windows_o),    m_win);
    chk("R8 done_o",       int'(done_o),       int'(m_mode == 4));
  end

  // pseudo-random stimulus (R9, R10 exercised in every phase)
  logic rnd_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk_i) begin
    if (rnd_en && !done_o) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lost_i  = (lfsr[4:0] == 5'd0);
      extra_i = (lfsr[9:5] == 5'd3);
      start_i = (lfsr[14:10] == 5'd7);
    end else if (rnd_en) begin
      lost_i = 1'b0; extra_i = 1'b0; start_i = 1'b0;
    end
  end

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 inject_o", int'(inject_o), 0);
    chk("R1 clear_o", int'(clear_o), 0);
    chk("R1 done_o", int'(done_o), 0);
    chk("R1 obs_cycles_o", int'(obs_cycles_o), 0);
    chk("R1 windows_o", int'(windows_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle stays idle", int'(clear_o), 0);

    // Run A: no events, every window hits the limit
    pulse_start();
    chk("R2 clear after start", int'(clear_o), 1);
    wait_done();
    chk("R5 full windows obs", int'(obs_cycles_o), NUM_WIN * WIN_LEN);
    chk("R6 no errors", int'(err_count_o), 0);
    chk("R7 all windows", int'(windows_o), NUM_WIN);
    repeat (5) @(negedge clk_i);
    chk("R8 stats held after run", int'(obs_cycles_o), NUM_WIN * WIN_LEN);

    // Run B: random events and start pulses
    pulse_start();
    chk("R2 stats zeroed on start", int'(windows_o), 0);
    rnd_en = 1'b1;
    wait_done();
    rnd_en = 1'b0;
    @(negedge clk_i);
    lost_i = 1'b0; extra_i = 1'b0; start_i = 1'b0;
    chk("R7 random run windows", int'(windows_o), NUM_WIN);
    repeat (3) @(negedge clk_i);

    // Run C: one event per window at offset j; j == WIN_LEN is the tie case (R6)
    begin
      int exp_obs = 0, exp_err = 0;
      pulse_start();
      for (int w = 0; w < NUM_WIN; w++) begin
        int j;
        while (!inject_o) @(negedge clk_i);
        j = (w % (WIN_LEN + 3)) + 1;
        exp_obs += (j < WIN_LEN) ? j : WIN_LEN;
        if (j <= WIN_LEN) exp_err++;
        repeat (j) @(negedge clk_i);
        if (w % 2 == 1) extra_i = 1'b1; else lost_i = 1'b1;
        @(negedge clk_i);
        lost_i = 1'b0; extra_i = 1'b0;
      end
      wait_done();
      chk("R4 directed obs sum", int'(obs_cycles_o), exp_obs);
      chk("R6 directed errors incl tie", int'(err_count_o), exp_err);
      chk("R10 events in clear ignored", int'(windows_o), NUM_WIN);
    end

    // R9: start ignored during a run (window count keeps climbing, not reset)
    pulse_start();
    repeat (60) @(negedge clk_i);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk("R9 start ignored mid-run", int'(windows_o) > 0 ? 1 : 0, 1);
    wait_done();
    chk("R9 run completes", int'(windows_o), NUM_WIN);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule